// File: doc/BRIEF.md
# Three-Wire Serial Control Register Interface

This block is the host-facing configuration port of a baseband voice and data front end. A host processor drives a serial clock, a strobe that also sets the direction, and one data line. When the strobe is high, the host shifts in write frames. Each frame is two address bits followed by eight data bits, most significant bit first. The frame takes effect only when the strobe falls. When the strobe is low, the block drives the data line with the most recent received-data byte, one bit per serial clock.

Four write addresses exist:

- **Control word:** path switches, power mode, frame-detect enable, scrambler bypass and output selection.
- **Second control word:** compander and emphasis enables, frame-pattern and carrier selection, and the receive-demodulator volume.
- **Transmit volume pair:** the transmit-input volume and the modulator-output volume.
- **Receive-voice word:** the receive-voice volume and the receiver switch. If any of its upper four bits is zero, this word sets a test-mode flag instead of loading those fields.

All register contents appear as decoded outputs. The three serial inputs are synchronised into the system clock domain, and every edge is detected there.

Top module: `ser_ctl_regs`

## Requirements
- R1: While reset is asserted, the outputs hold these defaults:
  - control word 1110_1100 on {frm_sel, pwr_mode[1:0], fdet_off, scr_byp, mod_off, tx_sel, rx_sel};
  - {cmpd_en, emph_en, pat_sel, car_sel} = 1101;
  - vol_rxd = vol_txi = vol_mod = 1000 and vol_rxv = 100;
  - rcv_sw = 0, test_mode = 0.
- R2: A frame with address 00 loads the eight data bits, first shifted data bit (D7) down to D0, onto {frm_sel, pwr_mode[1], pwr_mode[0], fdet_off, scr_byp, mod_off, tx_sel, rx_sel}. The first two serial bits are the address, high bit first.
- R3: Address 11 loads D7..D4 onto {cmpd_en, emph_en, pat_sel, car_sel} and D3..D0 onto vol_rxd.
- R4: Address 10 loads D7..D4 onto vol_txi and D3..D0 onto vol_mod.
- R5: Address 01 with D7..D4 = 1111 loads D3 onto rcv_sw and D2..D0 onto vol_rxv, and clears test_mode.
- R6: Address 01 with any of D7..D4 equal to 0 sets test_mode and leaves rcv_sw and vol_rxv unchanged.
- R7: No output register changes while the strobe is high. A complete frame takes effect only after the strobe falls.
- R8: A frame with fewer than 10 serial clocks before the strobe falls changes no register.
- R9: A frame with more than 10 serial clocks is decoded from its last 10 bits.
- R10: While the strobe is low, sdio_o presents the received byte MSB first. The bit advances on each serial clock rising edge. The byte is captured when the first bit is presented, and a new byte is taken after eight clocks.
- R11: sdio_oe_o is 0 while the strobe is high and during reset, and 1 while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host |
| strb_i | input | 1 | Strobe/direction: high = write frame, falling edge commits |
| sdio_i | input | 1 | Serial data from host |
| sdio_o | output | 1 | Serial read data to host |
| sdio_oe_o | output | 1 | Output enable for the shared data pin |
| rx_byte_i | input | 8 | Latest received-data byte |
| frm_sel_o | output | 1 | Selects receive-flag (1) or frame-detect (0) indication |
| pwr_mode_o | output | 2 | Power mode code |
| fdet_off_o | output | 1 | Frame detector disabled |
| scr_byp_o | output | 1 | Scrambler bypassed |
| mod_off_o | output | 1 | Data modulator off (voice path) |
| tx_sel_o | output | 1 | Transmit path switch |
| rx_sel_o | output | 1 | Receive path switch |
| cmpd_en_o | output | 1 | Compander enabled |
| emph_en_o | output | 1 | Emphasis enabled |
| pat_sel_o | output | 1 | Frame pattern select |
| car_sel_o | output | 1 | Inversion carrier select |
| vol_rxd_o | output | 4 | Receive-demodulator volume code |
| vol_txi_o | output | 4 | Transmit-input volume code |
| vol_mod_o | output | 4 | Modulator-output volume code |
| rcv_sw_o | output | 1 | Receiver switch |
| vol_rxv_o | output | 3 | Receive-voice volume code |
| test_mode_o | output | 1 | Test-mode flag |

## Verification
Two things happen on the same system-clock edge: a write commits when the strobe falls, and the read path starts driving the data pin. The write must land in the registers while the first read bit is already valid and comes from the byte presented during the frame.

The bench provokes this by ending a write frame and sampling sdio_o and the decoded outputs together right after the strobe fall. Both are judged against the bench's own register model and the byte it applied. A second case changes the received byte in the middle of a read, to show that the byte captured at the start is kept until all eight clocks are done.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTL1 = 2'b00,
    ADR_VRX  = 2'b01,
    ADR_VTX  = 2'b10,
    ADR_CTL2 = 2'b11
  } reg_addr_e;

  typedef struct packed {
    logic       frm_sel;
    logic [1:0] pwr_mode;
    logic       fdet_off;
    logic       scr_byp;
    logic       mod_off;
    logic       tx_sel;
    logic       rx_sel;
  } ctl1_t;

  typedef struct packed {
    logic cmpd_en;
    logic emph_en;
    logic pat_sel;
    logic car_sel;
  } ctl2_t;

  localparam ctl1_t      CTL1_RST = 8'b1110_1100;
  localparam ctl2_t      CTL2_RST = 4'b1101;
  localparam logic [3:0] VOL4_RST = 4'b1000;
  localparam logic [2:0] VOL3_RST = 3'b100;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int          N       = 1,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign lvl_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ser_wr_shift.sv
module ser_wr_shift #(
  parameter int FRAME_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               shift_i,
  input  logic               din_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               full_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (shift_i) begin
      sr_d = {sr_q[FRAME_W-2:0], din_i};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign frame_o = sr_q;
  assign full_o  = (cnt_q == CNT_MAX);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
endmodule

// File: rtl/ser_rd_shift.sv
module ser_rd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_mode_i,
  input  logic         step_i,
  input  logic [W-1:0] byte_i,
  output logic         bit_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (wr_mode_i) begin
      cnt_d = '0;
      sr_d  = byte_i;
    end else if (step_i) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        sr_d  = byte_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
        sr_d  = {sr_q[W-2:0], 1'b0};
      end
    end else if (cnt_q == '0) begin
      sr_d = byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_o = sr_q[W-1];

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_mode_i && !step_i && cnt_q != '0) |=> $stable(sr_q));
endmodule

// File: rtl/ser_regs.sv
module ser_regs
  import ser_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output ctl1_t             ctl1_o,
  output ctl2_t             ctl2_o,
  output logic [3:0]        vol_rxd_o,
  output logic [3:0]        vol_txi_o,
  output logic [3:0]        vol_mod_o,
  output logic              rcv_sw_o,
  output logic [2:0]        vol_rxv_o,
  output logic              test_o
);
  ctl1_t      ctl1_q, ctl1_d;
  ctl2_t      ctl2_q, ctl2_d;
  logic [3:0] vrd_q, vrd_d, vti_q, vti_d, vmo_q, vmo_d;
  logic       rsw_q, rsw_d, tm_q, tm_d;
  logic [2:0] vrv_q, vrv_d;

  always_comb begin
    ctl1_d = ctl1_q;
    ctl2_d = ctl2_q;
    vrd_d  = vrd_q;
    vti_d  = vti_q;
    vmo_d  = vmo_q;
    rsw_d  = rsw_q;
    vrv_d  = vrv_q;
    tm_d   = tm_q;
    if (commit_i) begin
      unique case (reg_addr_e'(addr_i))
        ADR_CTL1: ctl1_d = ctl1_t'(data_i);
        ADR_VRX: begin
          if (&data_i[7:4]) begin
            rsw_d = data_i[3];
            vrv_d = data_i[2:0];
            tm_d  = 1'b0;
          end else begin
            tm_d  = 1'b1;
          end
        end
        ADR_VTX: begin
          vti_d = data_i[7:4];
          vmo_d = data_i[3:0];
        end
        ADR_CTL2: begin
          ctl2_d = ctl2_t'(data_i[7:4]);
          vrd_d  = data_i[3:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q <= CTL1_RST;
      ctl2_q <= CTL2_RST;
      vrd_q  <= VOL4_RST;
      vti_q  <= VOL4_RST;
      vmo_q  <= VOL4_RST;
      rsw_q  <= 1'b0;
      vrv_q  <= VOL3_RST;
      tm_q   <= 1'b0;
    end else begin
      ctl1_q <= ctl1_d;
      ctl2_q <= ctl2_d;
      vrd_q  <= vrd_d;
      vti_q  <= vti_d;
      vmo_q  <= vmo_d;
      rsw_q  <= rsw_d;
      vrv_q  <= vrv_d;
      tm_q   <= tm_d;
    end
  end

  assign ctl1_o    = ctl1_q;
  assign ctl2_o    = ctl2_q;
  assign vol_rxd_o = vrd_q;
  assign vol_txi_o = vti_q;
  assign vol_mod_o = vmo_q;
  assign rcv_sw_o  = rsw_q;
  assign vol_rxv_o = vrv_q;
  assign test_o    = tm_q;

  // R6
  test_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && addr_i == 2'b01 && !(&data_i[7:4]))
      |=> (tm_q && $stable(rsw_q) && $stable(vrv_q)));

  // R5
  test_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && addr_i == 2'b01 && (&data_i[7:4])) |=> !tm_q);
endmodule

// File: rtl/ser_ctl_regs.sv
module ser_ctl_regs
  import ser_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       strb_i,
  input  logic       sdio_i,
  output logic       sdio_o,
  output logic       sdio_oe_o,
  input  logic [7:0] rx_byte_i,
  output logic       frm_sel_o,
  output logic [1:0] pwr_mode_o,
  output logic       fdet_off_o,
  output logic       scr_byp_o,
  output logic       mod_off_o,
  output logic       tx_sel_o,
  output logic       rx_sel_o,
  output logic       cmpd_en_o,
  output logic       emph_en_o,
  output logic       pat_sel_o,
  output logic       car_sel_o,
  output logic [3:0] vol_rxd_o,
  output logic [3:0] vol_txi_o,
  output logic [3:0] vol_mod_o,
  output logic       rcv_sw_o,
  output logic [2:0] vol_rxv_o,
  output logic       test_mode_o
);
  logic [2:0]         s_lvl;
  logic               sclk_s, strb_s, din_s;
  logic               sclk_prev_q, strb_prev_q;
  logic               sclk_rise, strb_rise, strb_fall;
  logic [FRAME_W-1:0] frame;
  logic               frame_full, commit;
  ctl1_t              ctl1;
  ctl2_t              ctl2;

  ser_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdio_i, strb_i, sclk_i}),
    .lvl_o   (s_lvl)
  );
  assign sclk_s = s_lvl[0];
  assign strb_s = s_lvl[1];
  assign din_s  = s_lvl[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      strb_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      strb_prev_q <= strb_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign strb_rise = strb_s & ~strb_prev_q;
  assign strb_fall = ~strb_s & strb_prev_q;
  assign commit    = strb_fall & frame_full;

  ser_wr_shift #(.FRAME_W(FRAME_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (strb_rise),
    .shift_i (sclk_rise & strb_s),
    .din_i   (din_s),
    .frame_o (frame),
    .full_o  (frame_full)
  );

  ser_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .addr_i    (frame[FRAME_W-1 -: ADDR_W]),
    .data_i    (frame[DATA_W-1:0]),
    .ctl1_o    (ctl1),
    .ctl2_o    (ctl2),
    .vol_rxd_o (vol_rxd_o),
    .vol_txi_o (vol_txi_o),
    .vol_mod_o (vol_mod_o),
    .rcv_sw_o  (rcv_sw_o),
    .vol_rxv_o (vol_rxv_o),
    .test_o    (test_mode_o)
  );

  ser_rd_shift #(.W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode_i (strb_s),
    .step_i    (sclk_rise),
    .byte_i    (rx_byte_i),
    .bit_o     (sdio_o)
  );

  assign sdio_oe_o  = ~strb_s;
  assign frm_sel_o  = ctl1.frm_sel;
  assign pwr_mode_o = ctl1.pwr_mode;
  assign fdet_off_o = ctl1.fdet_off;
  assign scr_byp_o  = ctl1.scr_byp;
  assign mod_off_o  = ctl1.mod_off;
  assign tx_sel_o   = ctl1.tx_sel;
  assign rx_sel_o   = ctl1.rx_sel;
  assign cmpd_en_o  = ctl2.cmpd_en;
  assign emph_en_o  = ctl2.emph_en;
  assign pat_sel_o  = ctl2.pat_sel;
  assign car_sel_o  = ctl2.car_sel;

  // R7
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_fall |=> ($stable(ctl1) && $stable(ctl2) && $stable(vol_txi_o)
                    && $stable(vol_mod_o) && $stable(vol_rxd_o)
                    && $stable(vol_rxv_o) && $stable(rcv_sw_o)));

  // R8
  short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && !frame_full) |=> ($stable(ctl1) && $stable(ctl2)
                    && $stable(vol_txi_o) && $stable(vol_mod_o)
                    && $stable(test_mode_o)));

  // R11
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_s |-> !sdio_oe_o);
endmodule

// File: tb/test_ser_ctl_regs.sv
module test_ser_ctl_regs;
  logic       clk = 1'b0;
  logic       rst_n, sclk_i, strb_i, sdio_i;
  logic       sdio_o, sdio_oe_o;
  logic [7:0] rx_byte_i;
  logic       frm_sel_o, fdet_off_o, scr_byp_o, mod_off_o, tx_sel_o, rx_sel_o;
  logic [1:0] pwr_mode_o;
  logic       cmpd_en_o, emph_en_o, pat_sel_o, car_sel_o, rcv_sw_o, test_mode_o;
  logic [3:0] vol_rxd_o, vol_txi_o, vol_mod_o;
  logic [2:0] vol_rxv_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [7:0] e_c1;
  logic [3:0] e_c2, e_vrd, e_vti, e_vmo;
  logic       e_rsw, e_tm;
  logic [2:0] e_vrv;

  always #10 clk = ~clk;

  ser_ctl_regs i_ser_ctl_regs (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .strb_i(strb_i),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o),
    .rx_byte_i(rx_byte_i), .frm_sel_o(frm_sel_o), .pwr_mode_o(pwr_mode_o),
    .fdet_off_o(fdet_off_o), .scr_byp_o(scr_byp_o), .mod_off_o(mod_off_o),
    .tx_sel_o(tx_sel_o), .rx_sel_o(rx_sel_o), .cmpd_en_o(cmpd_en_o),
    .emph_en_o(emph_en_o), .pat_sel_o(pat_sel_o), .car_sel_o(car_sel_o),
    .vol_rxd_o(vol_rxd_o), .vol_txi_o(vol_txi_o), .vol_mod_o(vol_mod_o),
    .rcv_sw_o(rcv_sw_o), .vol_rxv_o(vol_rxv_o), .test_mode_o(test_mode_o)
  );

  function automatic logic [28:0] got_vec();
    return {frm_sel_o, pwr_mode_o, fdet_off_o, scr_byp_o, mod_off_o, tx_sel_o,
            rx_sel_o, cmpd_en_o, emph_en_o, pat_sel_o, car_sel_o, vol_rxd_o,
            vol_txi_o, vol_mod_o, rcv_sw_o, vol_rxv_o, test_mode_o};
  endfunction

  function automatic logic [28:0] exp_vec();
    return {e_c1, e_c2, e_vrd, e_vti, e_vmo, e_rsw, e_vrv, e_tm};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [28:0] act,
                     input logic [28:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitpulse(input logic b);
    sdio_i = b; tick(3);
    sclk_i = 1'b1; tick(3);
    sclk_i = 1'b0; tick(1);
  endtask

  task automatic send(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) bitpulse(w[i]);
  endtask

  task automatic model(input logic [15:0] w, input int n);
    if (n >= 10) begin
      case (w[9:8])
        2'b00: e_c1 = w[7:0];
        2'b01: if (&w[7:4]) begin e_rsw = w[3]; e_vrv = w[2:0]; e_tm = 1'b0; end
               else e_tm = 1'b1;
        2'b10: begin e_vti = w[7:4]; e_vmo = w[3:0]; end
        default: begin e_c2 = w[7:4]; e_vrd = w[3:0]; end
      endcase
    end
  endtask

  task automatic frame(input logic [15:0] w, input int n, input string req);
    strb_i = 1'b1; tick(4);
    send(w, n);
    strb_i = 1'b0; tick(6);
    model(w, n);
    chk(got_vec() === exp_vec(), req, got_vec(), exp_vec());
  endtask

  initial begin
    rst_n = 1'b0; sclk_i = 1'b0; strb_i = 1'b0; sdio_i = 1'b0;
    rx_byte_i = 8'h00;
    e_c1 = 8'b1110_1100; e_c2 = 4'b1101; e_vrd = 4'b1000; e_vti = 4'b1000;
    e_vmo = 4'b1000; e_rsw = 1'b0; e_vrv = 3'b100; e_tm = 1'b0;
    tick(5);
    // R1 reset defaults
    chk(got_vec() === exp_vec(), "R1", got_vec(), exp_vec());
    // R11 pin released in reset
    chk(sdio_oe_o === 1'b0, "R11", 29'(sdio_oe_o), 29'd0);
    rst_n = 1'b1; tick(6);

    // R4 sweep of transmit volume pair
    for (int d = 0; d < 256; d++) frame({6'd0, 2'b10, 8'(d)}, 10, "R4");
    // R2 sweep of control word
    for (int d = 0; d < 256; d++) frame({6'd0, 2'b00, 8'(d)}, 10, "R2");
    // R3 sweep of second control word
    for (int d = 0; d < 256; d++) frame({6'd0, 2'b11, 8'(d)}, 10, "R3");
    // R5 / R6 sweep of receive-voice word and test flag
    for (int d = 0; d < 256; d++)
      frame({6'd0, 2'b01, 8'(d)}, 10, (d >= 240) ? "R5" : "R6");

    // R7 / R11: complete frame shifted, strobe still high
    strb_i = 1'b1; tick(4);
    send({6'd0, 2'b10, 8'h3C}, 10);
    tick(6);
    chk(got_vec() === exp_vec(), "R7", got_vec(), exp_vec());
    chk(sdio_oe_o === 1'b0, "R11", 29'(sdio_oe_o), 29'd0);
    strb_i = 1'b0; tick(6);
    model({6'd0, 2'b10, 8'h3C}, 10);
    chk(got_vec() === exp_vec(), "R7", got_vec(), exp_vec());
    chk(sdio_oe_o === 1'b1, "R11", 29'(sdio_oe_o), 29'd1);

    // R8 short frames
    for (int n = 1; n < 10; n++) frame({6'd0, 2'b00, 8'h5A}, n, "R8");
    frame({6'd0, 2'b01, 8'h0F}, 9, "R8");

    // R9 long frames: last ten bits count
    frame({4'hF, 2'b00, 2'b10, 8'h96}, 14, "R9");
    frame({4'h0, 2'b11, 2'b11, 8'h2B}, 12, "R9");

    // R10 read sweep
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v;
      v = 8'(k * 37 + 5);
      rx_byte_i = v; tick(4);
      for (int i = 7; i >= 0; i--) begin
        chk(sdio_o === v[i] && sdio_oe_o === 1'b1, "R10", 29'(sdio_o), 29'(v[i]));
        bitpulse(1'b0); tick(2);
      end
    end

    // R10 byte captured at read start is kept mid-read
    rx_byte_i = 8'hA5; tick(4);
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) rx_byte_i = 8'h5A;
      chk(sdio_o === ((8'hA5 >> i) & 1), "R10", 29'(sdio_o), 29'((8'hA5 >> i) & 1));
      bitpulse(1'b0); tick(2);
    end
    chk(sdio_o === 1'b0, "R10", 29'(sdio_o), 29'd0);

    // Commit and read start on the same edge (R2, R10)
    rx_byte_i = 8'hC3;
    frame({6'd0, 2'b00, 8'h71}, 10, "R2");
    chk(sdio_o === 1'b1 && sdio_oe_o === 1'b1, "R10", 29'(sdio_o), 29'd1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule